// File: doc/BRIEF.md
# Two-Bank Flow-Through Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst static memory. It has two banks and a data word built from byte lanes. Each lane carries eight data bits and one parity bit. On each rising clock edge the block samples the address, the two active-low bank enables, the two address-load strobes, the advance input and the write controls. A two-bit counter supplies the lowest address bits. It steps linearly and wraps inside an aligned block of four words, so a full burst takes one address cycle followed by three advance cycles.

The read path is flow-through. After an edge that registers a read, the array word at the registered address passes through combinational logic to the data outputs. An asynchronous output enable gates these outputs. Writes are self-timed: the write data is captured on the same edge that registers the write cycle. The data port is split into an input bus and an output bus, and a drive-enable flag marks when the output bus carries valid read data. When the flag is low, the output bus is all zeros.

A small state machine tracks the kind of access. It has three states: `ACC_IDLE` (deselected), `ACC_READ` and `ACC_WRITE`. Its transitions are the following:
- **rd-load**: read strobe with exactly one bank enabled, leading to `ACC_READ`.
- **any-load**: general strobe with exactly one bank enabled, leading to `ACC_READ` or `ACC_WRITE` according to the write controls.
- **deselect**: general strobe without exactly one bank enabled, leading to `ACC_IDLE`.
- **continue**: both strobes ineffective, so a non-idle state stays non-idle and takes its access type from the write controls. The idle state stays idle.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, and right after it is released, the block is in `ACC_IDLE`, `drive_en` is 0, and `data_out` and `par_out` are zero.
- R2: `rd_ld_n` low together with exactly one low bank enable registers `addr` and the bank, and starts a read. `bank_en_n[0]` low selects bank 0 and `bank_en_n[1]` low selects bank 1. The write controls are ignored, so memory is unchanged and the stored word is output.
- R3: `rd_ld_n` has no effect unless exactly one bank enable is low. From idle the block stays idle. During a burst the cycle is a continue cycle, so the address advances and is not reloaded.
- R4: `any_ld_n` low with exactly one bank enabled (and no effective `rd_ld_n`) registers `addr` and starts a write if any lane is write-enabled, otherwise a read.
- R5: `any_ld_n` low with both bank enables high, or both low (and no effective `rd_ld_n`), deselects: after that edge `drive_en` is 0 and the outputs are zero.
- R6: When both strobes are low and exactly one bank is enabled, `rd_ld_n` wins, so the cycle is a read even with `all_wr_n` low.
- R7: In a continue cycle with `adv_n` low, address bits [1:0] step by one and wrap from 3 to 0, while the upper bits and the bank stay unchanged.
- R8: In a continue cycle with `adv_n` high, the address stays the same.
- R9: `all_wr_n` low writes every lane, data and parity, regardless of `lane_gate_n` and `lane_wr_n`.
- R10: With `all_wr_n` high and `lane_gate_n` low, lane i (`data_in[8i+7:8i]` and `par_in[i]`) is written only when `lane_wr_n[i]` is low. The other lanes keep their contents.
- R11: With `all_wr_n` high and either `lane_gate_n` high or all `lane_wr_n` high, the cycle is a read and memory is unchanged.
- R12: `oe_n` high forces `drive_en` low and the outputs to zero at once, with no clock edge. `oe_n` low during a read restores the data.
- R13: Continue cycles keep the registered bank even when both enables are high. Each continue cycle is a read or a write according to the write controls of that cycle.
- R14: The two banks hold separate words at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address within a bank |
| bank_en_n | input | 2 | Bank enables, active low; bit i selects bank i |
| rd_ld_n | input | 1 | Read-load strobe, active low, gated by the bank enables |
| any_ld_n | input | 1 | General load strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high means wait |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_gate_n | input | 1 | Gate for the per-lane write enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| data_in | input | 8*LANES | Write data, lane i in bits [8i+7:8i] |
| par_in | input | LANES | Write parity, bit i for lane i |
| data_out | output | 8*LANES | Read data, zero when not driven |
| par_out | output | LANES | Read parity, zero when not driven |
| drive_en | output | 1 | High when read data is driven |

## Verification
The bench builds the block with `ADDR_W` = 4 and eight lanes, so each bank holds sixteen words. At that size a burst started at address 6 crosses the wrap from 3 to 0 inside its four-word block, and the same address can be compared across both banks in a few cycles. With eight lanes, a mixed lane-enable pattern exercises partial writes over the full 72-bit word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_t;

    localparam int BURST_W = 2;
    localparam int BYTE_W  = 8;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bank_en_n,
    input  logic              rd_ld_n,
    input  logic              any_ld_n,
    input  logic              adv_n,
    input  logic              all_wr_n,
    input  logic              lane_gate_n,
    input  logic [LANES-1:0]  lane_wr_n,
    output acc_t              acc_state,
    output logic [ADDR_W:0]   cur_addr,
    output logic              wr_en,
    output logic [ADDR_W:0]   wr_addr,
    output logic [LANES-1:0]  wr_mask
);
    acc_t                      state_q, state_d;
    logic                      bank_q, bank_d;
    logic [ADDR_W-1:BURST_W]   hi_q, hi_d;
    logic [BURST_W-1:0]        cnt_q, cnt_d;
    logic                      one_bank, rd_ok, wr_req;
    logic [LANES-1:0]          lane_mask;

    // Decode of the sampled controls
    always_comb begin
        one_bank  = (bank_en_n == 2'b01) || (bank_en_n == 2'b10);
        rd_ok     = !rd_ld_n && one_bank;
        if (!all_wr_n)
            lane_mask = '1;
        else if (!lane_gate_n)
            lane_mask = ~lane_wr_n;
        else
            lane_mask = '0;
        wr_req = |lane_mask;
    end

    // Next state and next address
    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        hi_d    = hi_q;
        cnt_d   = cnt_q;
        if (rd_ok) begin
            state_d = ACC_READ;
            bank_d  = bank_en_n[0];
            hi_d    = addr[ADDR_W-1:BURST_W];
            cnt_d   = addr[BURST_W-1:0];
        end else if (!any_ld_n) begin
            if (one_bank) begin
                state_d = wr_req ? ACC_WRITE : ACC_READ;
                bank_d  = bank_en_n[0];
                hi_d    = addr[ADDR_W-1:BURST_W];
                cnt_d   = addr[BURST_W-1:0];
            end else begin
                state_d = ACC_IDLE;
            end
        end else begin
            unique case (state_q)
                ACC_IDLE: state_d = ACC_IDLE;
                ACC_READ, ACC_WRITE: begin
                    state_d = wr_req ? ACC_WRITE : ACC_READ;
                    if (!adv_n)
                        cnt_d = cnt_q + BURST_W'(1);
                end
                default: state_d = ACC_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            bank_q  <= 1'b0;
            hi_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            hi_q    <= hi_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        acc_state = state_q;
        cur_addr  = {bank_q, hi_q, cnt_q};
        wr_en     = (state_d == ACC_WRITE);
        wr_addr   = {bank_d, hi_d, cnt_d};
        wr_mask   = lane_mask;
    end
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
    parameter int AW    = 7,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [1:0]            bank_en_n,
    input  logic                  rd_ld_n,
    input  logic                  any_ld_n,
    input  logic                  adv_n,
    input  logic                  all_wr_n,
    input  logic                  lane_gate_n,
    input  logic [LANES-1:0]      lane_wr_n,
    input  logic                  oe_n,
    input  logic [LANES*8-1:0]    data_in,
    input  logic [LANES-1:0]      par_in,
    output logic [LANES*8-1:0]    data_out,
    output logic [LANES-1:0]      par_out,
    output logic                  drive_en
);
    localparam int FULL_W = ADDR_W + 1;
    localparam int LANE_W = BYTE_W + 1;

    acc_t                  acc_state;
    logic [FULL_W-1:0]     cur_addr;
    logic [FULL_W-1:0]     wr_addr;
    logic                  wr_en;
    logic [LANES-1:0]      wr_mask;
    logic [LANES*8-1:0]    rd_data;
    logic [LANES-1:0]      rd_par;

    bsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .bank_en_n  (bank_en_n),
        .rd_ld_n    (rd_ld_n),
        .any_ld_n   (any_ld_n),
        .adv_n      (adv_n),
        .all_wr_n   (all_wr_n),
        .lane_gate_n(lane_gate_n),
        .lane_wr_n  (lane_wr_n),
        .acc_state  (acc_state),
        .cur_addr   (cur_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_mask    (wr_mask)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_rd;
        bsram_lane #(.AW(FULL_W), .WIDTH(LANE_W)) u_lane (
            .clk  (clk),
            .we   (wr_en && wr_mask[i]),
            .waddr(wr_addr),
            .wdata({par_in[i], data_in[i*BYTE_W +: BYTE_W]}),
            .raddr(cur_addr),
            .rdata(lane_rd)
        );
        assign rd_data[i*BYTE_W +: BYTE_W] = lane_rd[BYTE_W-1:0];
        assign rd_par[i]                   = lane_rd[BYTE_W];
    end

    assign drive_en = (acc_state == ACC_READ) && !oe_n;
    assign data_out = drive_en ? rd_data : '0;
    assign par_out  = drive_en ? rd_par  : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         bank_en_n,
    input logic               rd_ld_n,
    input logic               any_ld_n,
    input logic               adv_n,
    input logic               oe_n,
    input logic [ADDR_W-1:0]  addr,
    input acc_t               acc_state,
    input logic [ADDR_W:0]    cur_addr,
    input logic               drive,
    input logic [LANES*8-1:0] dout
);
    logic single_bank, rd_go, cont_cyc;

    always_comb begin
        single_bank = (bank_en_n == 2'b10) || (bank_en_n == 2'b01);
        rd_go       = !rd_ld_n && single_bank;
        cont_cyc    = !rd_go && any_ld_n;
    end

    // R2
    rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (acc_state == ACC_READ) &&
                  (cur_addr == {$past(bank_en_n[0]), $past(addr)}));

    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_go && !any_ld_n && !single_bank) |=> (acc_state == ACC_IDLE) && !drive);

    // R7
    adv_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cyc && !adv_n && acc_state != ACC_IDLE) |=>
            (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
            (cur_addr[ADDR_W:2] == $past(cur_addr[ADDR_W:2])));

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cyc && adv_n && acc_state != ACC_IDLE) |=> $stable(cur_addr));

    // R13
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_cyc && acc_state != ACC_IDLE) |=>
            (acc_state != ACC_IDLE) && (cur_addr[ADDR_W] == $past(cur_addr[ADDR_W])));

    // R12
    always_comb begin
        if (rst_n && oe_n) begin
            oe_quiet_chk: assert (!drive && dout == '0);
        end
    end
endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_en_n(bank_en_n),
    .rd_ld_n  (rd_ld_n),
    .any_ld_n (any_ld_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .acc_state(acc_state),
    .cur_addr (cur_addr),
    .drive    (drive_en),
    .dout     (data_out)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int LN    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [1:0]    bank_en_n;
    logic          rd_ld_n, any_ld_n, adv_n, all_wr_n, lane_gate_n, oe_n;
    logic [LN-1:0] lane_wr_n;
    logic [63:0]   data_in;
    logic [LN-1:0] par_in;
    logic [63:0]   data_out;
    logic [LN-1:0] par_out;
    logic          drive_en;

    logic [71:0]   mdl [2][16];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LN)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bank_en_n(bank_en_n),
        .rd_ld_n(rd_ld_n), .any_ld_n(any_ld_n), .adv_n(adv_n),
        .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .data_in(data_in), .par_in(par_in),
        .data_out(data_out), .par_out(par_out), .drive_en(drive_en)
    );

    task automatic check(string req, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        rd_ld_n = 1'b1; any_ld_n = 1'b1; adv_n = 1'b1; all_wr_n = 1'b1;
        lane_gate_n = 1'b1; lane_wr_n = '1; bank_en_n = 2'b11; addr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(logic [71:0] w);
        data_in = w[63:0];
        par_in  = w[71:64];
    endtask

    function automatic logic [71:0] word_out();
        return {par_out, data_out};
    endfunction

    function automatic logic [71:0] pat(int k);
        return {8'(8'hA0 + k), 64'h1122_3344_5566_7788 + 64'(k * 64'h0101_0101)};
    endfunction

    // read burst via read strobe, write controls set to a write (must be ignored)
    task automatic read_burst(string req, bit bank, logic [3:0] start, int n);
        logic [3:0] a;
        quiet();
        rd_ld_n = 1'b0; bank_en_n = bank ? 2'b01 : 2'b10; addr = start;
        all_wr_n = 1'b0; put(72'hDEAD_BEEF_DEAD_BEEF_DE);
        tick();
        check(req, word_out(), mdl[bank][start]);
        for (int k = 1; k < n; k++) begin
            quiet(); adv_n = 1'b0;
            tick();
            a = {start[3:2], 2'(start[1:0] + 2'(k))};
            check(req, word_out(), mdl[bank][a]);
        end
        quiet();
    endtask

    task automatic t_reset();
        quiet(); oe_n = 1'b0; put('0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check("R1", {71'd0, drive_en}, 72'd0);
        rst_n = 1'b1;
        tick();
        check("R1", {word_out()[71:1], drive_en}, 72'd0);
    endtask

    task automatic t_gw_burst();
        logic [3:0] a;
        // R9: lane gate active but all lane enables off, global write still writes all
        quiet();
        any_ld_n = 1'b0; bank_en_n = 2'b10; addr = 4'd6;
        all_wr_n = 1'b0; lane_gate_n = 1'b0; lane_wr_n = '1; put(pat(0));
        mdl[0][6] = pat(0);
        tick();
        check("R9", {71'd0, drive_en}, 72'd0);
        for (int k = 1; k < 4; k++) begin
            quiet(); adv_n = 1'b0; all_wr_n = 1'b0; lane_gate_n = 1'b0;
            put(pat(k));
            a = {2'b01, 2'(2'd2 + 2'(k))};
            mdl[0][a] = pat(k);
            tick();
        end
        quiet();
        // R7 and R2: wrap 2,3,0,1 read back, write controls ignored on load
        read_burst("R7", 1'b0, 4'd6, 4);
        read_burst("R2", 1'b0, 4'd4, 1);
    endtask

    task automatic t_suspend();
        read_burst("R8", 1'b0, 4'd6, 1);
        quiet(); adv_n = 1'b1;
        tick();
        // R8
        check("R8", word_out(), mdl[0][6]);
        quiet(); adv_n = 1'b0;
        tick();
        check("R8", word_out(), mdl[0][7]);
        quiet();
    endtask

    task automatic t_lane_write();
        logic [71:0] nw, old, res;
        nw = 72'h5A_F0E1_D2C3_B4A5_9687;
        old = mdl[0][6];
        res = old;
        for (int i = 0; i < 8; i++) begin
            if (!(8'b1010_0101 >> i & 8'd1)) begin
                res[8*i +: 8] = nw[8*i +: 8];
                res[64 + i]   = nw[64 + i];
            end
        end
        quiet();
        any_ld_n = 1'b0; bank_en_n = 2'b10; addr = 4'd6;
        lane_gate_n = 1'b0; lane_wr_n = 8'b1010_0101; put(nw);
        mdl[0][6] = res;
        tick();
        quiet();
        // R10
        read_burst("R10", 1'b0, 4'd6, 1);
    endtask

    task automatic t_no_write();
        // R4, R11: general strobe without any lane enable is a read
        quiet();
        any_ld_n = 1'b0; bank_en_n = 2'b10; addr = 4'd7;
        lane_wr_n = '0; put(72'h11_1111_1111_1111_1111);
        tick();
        check("R4", word_out(), mdl[0][7]);
        check("R4", {71'd0, drive_en}, 72'd1);
        quiet();
        any_ld_n = 1'b0; bank_en_n = 2'b10; addr = 4'd7;
        lane_gate_n = 1'b0; lane_wr_n = '1; put(72'h22_2222_2222_2222_2222);
        tick();
        check("R11", word_out(), mdl[0][7]);
        quiet();
        read_burst("R11", 1'b0, 4'd7, 1);
    endtask

    task automatic t_both_strobes();
        quiet();
        rd_ld_n = 1'b0; any_ld_n = 1'b0; bank_en_n = 2'b10; addr = 4'd4;
        all_wr_n = 1'b0; put(72'h33_3333_3333_3333_3333);
        tick();
        // R6
        check("R6", word_out(), mdl[0][4]);
        quiet();
        read_burst("R6", 1'b0, 4'd4, 1);
    endtask

    task automatic t_rd_gate();
        read_burst("R3", 1'b0, 4'd4, 1);
        quiet(); rd_ld_n = 1'b0; bank_en_n = 2'b11; adv_n = 1'b0; addr = 4'd0;
        tick();
        // R3: advanced to 5, not reloaded to 0
        check("R3", word_out(), mdl[0][5]);
        quiet(); any_ld_n = 1'b0; bank_en_n = 2'b11;
        tick();
        quiet(); rd_ld_n = 1'b0; bank_en_n = 2'b11; addr = 4'd6;
        tick();
        check("R3", {71'd0, drive_en}, 72'd0);
        quiet();
    endtask

    task automatic t_deselect();
        read_burst("R5", 1'b0, 4'd6, 1);
        quiet(); any_ld_n = 1'b0; bank_en_n = 2'b11;
        tick();
        // R5
        check("R5", {word_out()[71:1], drive_en}, 72'd0);
        read_burst("R5", 1'b0, 4'd6, 1);
        quiet(); any_ld_n = 1'b0; bank_en_n = 2'b00;
        tick();
        check("R5", {word_out()[71:1], drive_en}, 72'd0);
        quiet();
    endtask

    task automatic t_oe();
        read_burst("R12", 1'b0, 4'd6, 1);
        oe_n = 1'b1;
        #1;
        // R12
        check("R12", {word_out()[71:1], drive_en}, 72'd0);
        oe_n = 1'b0;
        #1;
        check("R12", word_out(), mdl[0][6]);
    endtask

    task automatic t_banks();
        // R14: bank 1 written at address 6, then continue write to 7 with enables high
        quiet();
        any_ld_n = 1'b0; bank_en_n = 2'b01; addr = 4'd6; all_wr_n = 1'b0;
        put(pat(20));
        mdl[1][6] = pat(20);
        tick();
        quiet(); adv_n = 1'b0; all_wr_n = 1'b0; put(pat(21));
        mdl[1][7] = pat(21);
        tick();
        quiet();
        read_burst("R14", 1'b0, 4'd6, 1);
        read_burst("R14", 1'b1, 4'd6, 2);
        // R13: read load in bank 1, then suspend cycle with write controls
        read_burst("R13", 1'b1, 4'd6, 1);
        quiet(); all_wr_n = 1'b0; put(pat(22));
        mdl[1][6] = pat(22);
        tick();
        check("R13", {71'd0, drive_en}, 72'd0);
        quiet();
        tick();
        check("R13", word_out(), mdl[1][6]);
        read_burst("R13", 1'b0, 4'd6, 1);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_gw_burst();
        t_suspend();
        t_lane_write();
        t_no_write();
        t_both_strobes();
        t_rd_gate();
        t_deselect();
        t_oe();
        t_banks();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule